// File: doc/BRIEF.md
# Banked Register File with Broadcast and Conflict Serialization

This block holds the register state that four functional units read. The storage is split into eight banks. Each bank has one read port and one write port and holds 32 words of 32 bits. The low bits of a register number pick the bank, so registers with consecutive numbers sit in different banks. Four requesters that walk through neighbouring registers are therefore all served in the same cycle.

Each requester has a valid/ready pair and an 8-bit register address. In every bank, the lowest-numbered requester that is waiting picks the one word that the bank reads in that cycle. Every waiting requester that names that same word is served by the same read, so one read is broadcast to all of them. A requester that names a different word in a busy bank keeps ready low. It must hold its request until a later cycle. A true conflict therefore costs one read cycle for each distinct word.

Read data is combinational from the selected bank word. A write lands on the next clock edge. Each bank's write port works on its own. A read that meets a write to the same word in the same cycle returns the contents from before the write.

Top module: `banked_regfile`

## Requirements
- R1: After reset every word reads as zero, and with no request valid all `rd_ready` bits are low.
- R2: Register address bits [2:0] select the bank and bits [7:3] select the word within that bank.
- R3: Requests that target different banks are all granted (ready high) in the same cycle.
- R4: All valid requesters that name the same register receive ready and identical data in the same cycle (broadcast).
- R5: Within a bank, the word served is the one named by the lowest-index valid requester. A valid requester naming another word in that bank has ready low, and requester 0 is always granted when valid.
- R6: A group of requests that stays held until granted completes in as many cycles as the largest number of distinct words requested from any single bank.
- R7: When `wr_en[b]` is high at a clock edge, the word at `wr_word` slice b of bank b takes `wr_data` slice b. All eight banks may write in the same cycle.
- R8: A read of a word that is being written in the same cycle returns the old value. The new value is returned from the next cycle on.
- R9: `rd_ready[i]` is never high while `rd_valid[i]` is low.
- R10: When `rd_ready[i]` is high, `rd_data` slice i equals the stored word at the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all words |
| rd_valid | input | 4 | Per-requester read request |
| rd_addr | input | 32 | Four 8-bit register addresses, requester i at bits [8i+7:8i] |
| rd_ready | output | 4 | Per-requester grant; data is valid in the same cycle |
| rd_data | output | 128 | Four 32-bit read results, requester i at bits [32i+31:32i] |
| wr_en | input | 8 | Per-bank write enable |
| wr_word | input | 40 | Eight 5-bit word indices, bank b at bits [5b+4:5b] |
| wr_data | input | 256 | Eight 32-bit write values, bank b at bits [32b+31:32b] |

## Verification
Broadcast and conflict serialization can occur in the same cycle within one bank. In that case two requesters share a word while a third names a different word in the same bank. The bench builds such groups, including one where requester 0 is idle and priority passes to the next requester. It predicts the grant vector of every cycle and the total number of cycles from its own model. A bank write also lands in the same cycle as a four-way broadcast read of that word. The read must carry the old value, and the follow-up group must see the new one.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NREQ  = 4,
  parameter int NBANK = 8,
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREQ-1:0]             rd_valid,
  input  logic [NREQ*($clog2(NBANK)+$clog2(DEPTH))-1:0] rd_addr,
  output logic [NREQ-1:0]             rd_ready,
  output logic [NREQ*DW-1:0]          rd_data,
  input  logic [NBANK-1:0]            wr_en,
  input  logic [NBANK*$clog2(DEPTH)-1:0] wr_word,
  input  logic [NBANK*DW-1:0]         wr_data
);
  localparam int BW = $clog2(NBANK);
  localparam int WW = $clog2(DEPTH);
  localparam int AW = BW + WW;

  logic [BW-1:0] req_bank [NREQ];
  logic [WW-1:0] req_word [NREQ];
  logic [WW-1:0] sel_word [NBANK];
  logic [DW-1:0] bank_q   [NBANK];

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    assign req_bank[i] = rd_addr[i*AW +: BW];
    assign req_word[i] = rd_addr[i*AW+BW +: WW];
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      sel_word[b] = '0;
      for (int i = NREQ-1; i >= 0; i--)
        if (rd_valid[i] && req_bank[i] == BW'(b))
          sel_word[b] = req_word[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      rd_ready[i]         = rd_valid[i] && (sel_word[req_bank[i]] == req_word[i]);
      rd_data[i*DW +: DW] = bank_q[req_bank[i]];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) store[w] <= '0;
      end else if (wr_en[b]) begin
        store[wr_word[b*WW +: WW]] <= wr_data[b*DW +: DW];
      end
    end

    assign bank_q[b] = store[sel_word[b]];
  end

  a_r5_req0_served: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid[0] |-> rd_ready[0]);

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready[i] |-> rd_valid[i]);

    a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready[i] && $past(rd_ready[i]) && $past(rst_n) &&
       rd_addr[i*AW +: AW] == $past(rd_addr[i*AW +: AW]) && $past(wr_en) == '0)
      |-> $stable(rd_data[i*DW +: DW]));

    for (genvar j = 0; j < NREQ; j++) begin : g_pair
      if (i != j) begin : g_ne
        a_r5_one_word_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_ready[i] && rd_ready[j] && req_bank[i] == req_bank[j])
          |-> req_word[i] == req_word[j]);

        a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_ready[j] && rd_valid[i] && rd_addr[i*AW +: AW] == rd_addr[j*AW +: AW])
          |-> (rd_ready[i] && rd_data[i*DW +: DW] == rd_data[j*DW +: DW]));
      end
    end
  end
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]   rd_valid;
  logic [31:0]  rd_addr;
  logic [3:0]   rd_ready;
  logic [127:0] rd_data;
  logic [7:0]   wr_en;
  logic [39:0]  wr_word;
  logic [255:0] wr_data;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data)
  );

  typedef struct {
    logic [3:0]   rdy;
    logic [127:0] d;
    string        tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] ref_mem [256];
  int          compared = 0;
  int          mismatched = 0;
  logic [7:0]  wq_en;
  logic [4:0]  wq_word [8];
  logic [31:0] wq_data [8];

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h3c, 8'h5a};
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic batch(input logic [3:0] v, input logic [7:0] a0, a1, a2, a3,
                       input string tag, input int exp_cycles);
    logic [7:0]   ad [4];
    logic [3:0]   pend;
    logic [3:0]   er;
    logic [127:0] ed;
    int           cyc;
    ad[0] = a0; ad[1] = a1; ad[2] = a2; ad[3] = a3;
    pend = v;
    cyc = 0;
    do begin
      @(posedge clk); #1;
      rd_valid = pend;
      for (int i = 0; i < 4; i++) rd_addr[i*8 +: 8] = ad[i];
      wr_en = wq_en;
      for (int b = 0; b < 8; b++) begin
        wr_word[b*5 +: 5]  = wq_word[b];
        wr_data[b*32 +: 32] = wq_data[b];
      end
      er = '0;
      ed = '0;
      for (int i = 0; i < 4; i++) begin
        int first = -1;
        for (int j = 3; j >= 0; j--)
          if (pend[j] && ad[j][2:0] == ad[i][2:0]) first = j;
        if (pend[i] && ad[first][7:3] == ad[i][7:3]) er[i] = 1'b1;
        ed[i*32 +: 32] = ref_mem[ad[i]];
      end
      sb.push_back('{rdy: er, d: ed, tag: tag});
      for (int b = 0; b < 8; b++)
        if (wq_en[b]) ref_mem[{wq_word[b], 3'(b)}] = wq_data[b];
      wq_en = '0;
      pend = pend & ~er;
      cyc++;
    end while (pend != '0 && cyc < 50);
    compared++;
    if (cyc != exp_cycles) begin
      mismatched++;
      $display("FAIL R6 %s: cycles actual %0d expected %0d", tag, cyc, exp_cycles);
    end
    @(posedge clk); #1;
    rd_valid = '0;
    wr_en = '0;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (rd_ready !== it.rdy) begin
        mismatched++;
        $display("FAIL R5 %s: rd_ready actual %b expected %b", it.tag, rd_ready, it.rdy);
      end
      for (int i = 0; i < 4; i++) begin
        if (it.rdy[i]) begin
          compared++;
          if (rd_data[i*32 +: 32] !== it.d[i*32 +: 32]) begin
            mismatched++;
            $display("FAIL R10 %s: req%0d data actual %h expected %h",
                     it.tag, i, rd_data[i*32 +: 32], it.d[i*32 +: 32]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
  end

  initial begin
    rd_valid = '0; rd_addr = '0; wr_en = '0; wr_word = '0; wr_data = '0;
    wq_en = '0;
    for (int b = 0; b < 8; b++) begin wq_word[b] = '0; wq_data[b] = '0; end
    for (int a = 0; a < 256; a++) ref_mem[a] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    batch(4'b0000, 0, 0, 0, 0, "R1 idle no ready", 1);
    batch(4'b1111, 0, 1, 2, 3, "R1 R3 zero after reset", 1);

    for (int w = 0; w < 32; w++) begin
      wq_en = 8'hff;
      for (int b = 0; b < 8; b++) begin
        wq_word[b] = 5'(w);
        wq_data[b] = pat({5'(w), 3'(b)});
      end
      batch(4'b0000, 0, 0, 0, 0, "R7 fill all banks", 1);
    end

    batch(4'b1111, 8, 9, 10, 11, "R2 R3 R7 consecutive", 1);
    batch(4'b1111, 20, 21, 22, 23, "R3 consecutive wrap", 1);
    batch(4'b1111, 13, 13, 13, 13, "R4 broadcast four", 1);
    batch(4'b1111, 0, 8, 16, 24, "R5 R6 four-way conflict", 4);
    batch(4'b1111, 5, 13, 5, 6, "R4 R5 R6 broadcast plus conflict", 2);
    batch(4'b1110, 0, 16, 8, 8, "R5 R6 priority without req0", 2);
    batch(4'b0101, 3, 3, 11, 3, "R9 invalid sharers stay low", 2);

    wq_en = 8'b0000_0010; wq_word[1] = 5'd1; wq_data[1] = 32'hdeadbeef;
    batch(4'b1111, 9, 9, 9, 9, "R8 read during write old", 1);
    batch(4'b1111, 9, 9, 1, 17, "R8 new value visible", 3);

    wq_en = 8'b1000_0000; wq_word[7] = 5'd31; wq_data[7] = 32'h12345678;
    batch(4'b0000, 0, 0, 0, 0, "R7 single bank write", 1);
    batch(4'b1111, 255, 7, 254, 247, "R2 bank select high bits", 3);

    repeat (3) @(posedge clk);
    report();
  end
endmodule